// File: doc/BRIEF.md
# Utilization-Based Interrupt Coalescer

This block decides when one traffic direction of a network interface should raise a completion interrupt. It counts completed frames and keeps a microsecond interval timer. It drives two separate interrupt pulses: one for utilization and frame count, and one for the timer. A neighbouring unit measures link utilization. That unit presents the result as a percentage with a strobe. The coalescer keeps the latest sample and uses it to select one of four utilization bands. Each band has its own frame-count threshold. When traffic is light, the interrupt can be raised after only a few frames. When the link is busy, more frames are gathered per interrupt.

The timer is a second, independent source. In its default mode it fires only if frames have completed since its last expiry. In continuous mode it fires at every interval. With auto-cancel set, a utilization interrupt restarts the timer interval. All configuration arrives on static input ports. A master enable clears all state and silences both outputs while it is low.

Top module: `util_intr_coalescer`

## Requirements
- R1: While `rstN` is low or `enable` is low, both interrupt outputs are low. The frame counter, the interval timer and the traffic flag are held cleared, and frames and ticks arriving in that time have no effect once the block is enabled again.
- R2: Band i (0 to 3, lettered A to D) takes its bound from `bandBounds[7i+6:7i]` and its threshold from `bandThresholds[16i+15:16i]`. The active band is the lowest-indexed band whose bound is greater than or equal to the last sampled utilization. A threshold of zero acts as one.
- R3: When the sampled utilization exceeds every bound, no utilization interrupt is raised, but frames are still counted.
- R4: When the frame count reaches the active band's threshold, `utilIrq` is high during the following clock cycle.
- R5: Issuing a utilization interrupt clears the frame counter. A frame that completes in that same cycle becomes the first count of the new batch.
- R6: The frame counter saturates at 65535 and never wraps.
- R7: The timer expires on the `timerInterval`-th `usTick` since its last restart. With continuous mode off, `timerIrq` pulses in the cycle after an expiry only if at least one frame completed since the previous expiry; each expiry consumes that traffic. An interval of zero stops the timer.
- R8: With continuous mode on, `timerIrq` pulses once per interval with no traffic at all.
- R9: With auto-cancel on, a utilization interrupt restarts the timer interval, and a timer expiry in that same cycle is dropped.
- R10: With auto-cancel off, the two outputs are independent and may pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; low clears all state |
| frameDone | input | 1 | One-cycle pulse per completed frame |
| utilValid | input | 1 | Strobe that loads `utilPct` |
| utilPct | input | 7 | Link utilization percentage, 0 to 100 |
| usTick | input | 1 | One-cycle pulse per microsecond |
| bandBounds | input | 28 | Four 7-bit utilization bounds, band A in the low bits |
| bandThresholds | input | 64 | Four 16-bit frame-count thresholds, band A in the low bits |
| timerInterval | input | 16 | Timer interval in microseconds, 0 stops the timer |
| autoCancelEn | input | 1 | Utilization interrupt restarts the timer |
| continuousEn | input | 1 | Timer fires without traffic |
| utilIrq | output | 1 | Utilization / frame-count interrupt pulse |
| timerIrq | output | 1 | Timer interrupt pulse |

## Verification
The checks assume that the configuration ports are static while frames and ticks flow. The auto-cancel check reads back the previous cycle's `autoCancelEn` on that basis. The bench therefore changes bounds, thresholds, interval and mode bits only while `enable` is low, or during idle cycles with no pending event. The checks also assume that `frameDone`, `usTick` and `utilValid` are single-cycle strobes sampled on the rising edge. The bench drives every strobe from the falling edge and holds it for exactly one cycle. It updates utilization only through `utilValid`, at least one cycle before the frames that depend on it.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // Strobes from the control module back into the datapath.
  typedef struct packed {
    logic clearCount;    // utilization interrupt issued this cycle
    logic restartTimer;  // auto-cancel: restart the interval timer
  } coalStrobeS;
endpackage

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int NUM_BANDS = 4,
  parameter int PCT_W     = 7,
  parameter int CNT_W     = 16,
  parameter int TMR_W     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       frameDone,
  input  logic                       utilValid,
  input  logic [PCT_W-1:0]           utilPct,
  input  logic                       usTick,
  input  logic [NUM_BANDS*PCT_W-1:0] bandBounds,
  input  logic [NUM_BANDS*CNT_W-1:0] bandThresholds,
  input  logic [TMR_W-1:0]           timerInterval,
  input  coalStrobeS                 strobe,
  output logic [CNT_W-1:0]           frameCnt,
  output logic                       bandHit,
  output logic                       countMet,
  output logic                       expireRaw
);
  localparam int BAND_IDX_W = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PCT_W-1:0]      utilSample;
  logic [PCT_W-1:0]      boundArr  [NUM_BANDS];
  logic [CNT_W-1:0]      threshArr [NUM_BANDS];
  logic [NUM_BANDS-1:0]  hitVec;
  logic [BAND_IDX_W-1:0] bandSel;
  logic [CNT_W-1:0]      selThresh;
  logic [CNT_W-1:0]      effThresh;
  logic [TMR_W-1:0]      usCnt;
  logic                  timerOn;

  // Latest utilization sample from the measurement unit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          utilSample <= '0;
    else if (utilValid) utilSample <= utilPct;
  end

  // Unpack the band configuration and compare each bound.
  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
    assign boundArr[g]  = bandBounds[g*PCT_W +: PCT_W];
    assign threshArr[g] = bandThresholds[g*CNT_W +: CNT_W];
    assign hitVec[g]    = (boundArr[g] >= utilSample);
  end

  // The lowest-indexed band that matches has priority; the last band is the default.
  always_comb begin
    bandSel = BAND_IDX_W'(NUM_BANDS - 1);
    for (int i = NUM_BANDS - 1; i >= 0; i--) begin
      if (hitVec[i]) bandSel = BAND_IDX_W'(i);
    end
  end

  assign bandHit   = |hitVec;
  assign selThresh = threshArr[bandSel];
  assign effThresh = (selThresh == '0) ? CNT_W'(1) : selThresh;
  assign countMet  = bandHit && (frameCnt >= effThresh);

  // Saturating frame counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  frameCnt <= '0;
    else if (!enable)           frameCnt <= '0;
    else if (strobe.clearCount) frameCnt <= frameDone ? CNT_W'(1) : '0;
    else if (frameDone && frameCnt != CNT_MAX)
                                frameCnt <= frameCnt + CNT_W'(1);
  end

  // Microsecond interval timer.
  assign timerOn   = enable && (timerInterval != '0);
  assign expireRaw = timerOn && usTick && (usCnt >= timerInterval - TMR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    usCnt <= '0;
    else if (!timerOn)            usCnt <= '0;
    else if (strobe.restartTimer) usCnt <= '0;
    else if (usTick)              usCnt <= expireRaw ? '0 : usCnt + TMR_W'(1);
  end
endmodule

// File: rtl/coal_control.sv
module coal_control
  import coal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       frameDone,
  input  logic       autoCancelEn,
  input  logic       continuousEn,
  input  logic       countMet,
  input  logic       expireRaw,
  output coalStrobeS strobe,
  output logic       utilIrq,
  output logic       timerIrq
);
  logic utilFire;
  logic timerFire;
  logic expireKept;
  logic trafficSeen;

  assign utilFire            = enable && countMet;
  assign strobe.clearCount   = utilFire;
  assign strobe.restartTimer = utilFire && autoCancelEn;

  // An expiry that coincides with auto-cancel is dropped.
  assign expireKept = expireRaw && !strobe.restartTimer;
  assign timerFire  = expireKept && (continuousEn || trafficSeen || frameDone);

  // Traffic since the last expiry that was kept.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           trafficSeen <= 1'b0;
    else if (!enable)    trafficSeen <= 1'b0;
    else if (expireKept) trafficSeen <= 1'b0;
    else if (frameDone)  trafficSeen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      utilIrq  <= 1'b0;
      timerIrq <= 1'b0;
    end else begin
      utilIrq  <= utilFire;
      timerIrq <= timerFire;
    end
  end
endmodule

// File: rtl/util_intr_coalescer.sv
module util_intr_coalescer
  import coal_pkg::*;
#(
  parameter int NUM_BANDS = 4,
  parameter int PCT_W     = 7,
  parameter int CNT_W     = 16,
  parameter int TMR_W     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       frameDone,
  input  logic                       utilValid,
  input  logic [PCT_W-1:0]           utilPct,
  input  logic                       usTick,
  input  logic [NUM_BANDS*PCT_W-1:0] bandBounds,
  input  logic [NUM_BANDS*CNT_W-1:0] bandThresholds,
  input  logic [TMR_W-1:0]           timerInterval,
  input  logic                       autoCancelEn,
  input  logic                       continuousEn,
  output logic                       utilIrq,
  output logic                       timerIrq
);
  coalStrobeS       strobe;
  logic [CNT_W-1:0] frameCnt;
  logic             bandHit;
  logic             countMet;
  logic             expireRaw;

  coal_datapath #(
    .NUM_BANDS(NUM_BANDS), .PCT_W(PCT_W), .CNT_W(CNT_W), .TMR_W(TMR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .frameDone(frameDone),
    .utilValid(utilValid), .utilPct(utilPct), .usTick(usTick),
    .bandBounds(bandBounds), .bandThresholds(bandThresholds),
    .timerInterval(timerInterval), .strobe(strobe),
    .frameCnt(frameCnt), .bandHit(bandHit), .countMet(countMet),
    .expireRaw(expireRaw)
  );

  coal_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .frameDone(frameDone),
    .autoCancelEn(autoCancelEn), .continuousEn(continuousEn),
    .countMet(countMet), .expireRaw(expireRaw), .strobe(strobe),
    .utilIrq(utilIrq), .timerIrq(timerIrq)
  );
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             usTick,
  input logic             autoCancelEn,
  input logic             utilIrq,
  input logic             timerIrq,
  input logic [CNT_W-1:0] frameCnt,
  input logic             bandHit,
  input logic             countMet
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!utilIrq && !timerIrq));

  // R3
  no_band_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bandHit |=> !utilIrq);

  // R4
  threshold_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && countMet) |=> utilIrq);

  // R5
  count_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    utilIrq |-> (frameCnt <= CNT_W'(1)));

  // R6
  count_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !countMet && frameCnt == CNT_MAX) |=> (frameCnt == CNT_MAX));

  // R7
  timer_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |-> $past(usTick));

  // R9
  cancel_drops_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (utilIrq && $past(autoCancelEn)) |-> !timerIrq);
endmodule

bind util_intr_coalescer coal_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .usTick(usTick),
  .autoCancelEn(autoCancelEn), .utilIrq(utilIrq), .timerIrq(timerIrq),
  .frameCnt(frameCnt), .bandHit(bandHit), .countMet(countMet)
);

// File: tb/util_intr_coalescer_tb.sv
`timescale 1ns/1ps
module util_intr_coalescer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        frameDone = 1'b0;
  logic        utilValid = 1'b0;
  logic [6:0]  utilPct = '0;
  logic        usTick = 1'b0;
  logic [27:0] bandBounds;
  logic [63:0] bandThresholds;
  logic [15:0] timerInterval = '0;
  logic        autoCancelEn = 1'b0;
  logic        continuousEn = 1'b0;
  logic        utilIrq;
  logic        timerIrq;

  int checks = 0;
  int errors = 0;
  int utilPulses = 0;
  int timerPulses = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  util_intr_coalescer u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .frameDone(frameDone),
    .utilValid(utilValid), .utilPct(utilPct), .usTick(usTick),
    .bandBounds(bandBounds), .bandThresholds(bandThresholds),
    .timerInterval(timerInterval), .autoCancelEn(autoCancelEn),
    .continuousEn(continuousEn), .utilIrq(utilIrq), .timerIrq(timerIrq)
  );

  always @(negedge clk) begin
    if (utilIrq)  utilPulses++;
    if (timerIrq) timerPulses++;
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setBands(input int b0, b1, b2, b3, t0, t1, t2, t3);
    bandBounds     = {7'(b3), 7'(b2), 7'(b1), 7'(b0)};
    bandThresholds = {16'(t3), 16'(t2), 16'(t1), 16'(t0)};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Re-enable the block so that each scenario starts from cleared state.
  task automatic restart();
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    idle(1);
    utilPulses = 0;
    timerPulses = 0;
  endtask

  task automatic setUtil(input int pct);
    @(negedge clk) begin utilValid = 1'b1; utilPct = 7'(pct); end
    @(negedge clk) utilValid = 1'b0;
  endtask

  task automatic sendFrames(input int n);
    for (int i = 0; i < n; i++) @(negedge clk) frameDone = 1'b1;
    @(negedge clk) frameDone = 1'b0;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) usTick = 1'b1;
      @(negedge clk) usTick = 1'b0;
    end
  endtask

  task automatic testReset();
    checkEq("R1", "utilIrq in reset", int'(utilIrq), 0);
    checkEq("R1", "timerIrq in reset", int'(timerIrq), 0);
  endtask

  task automatic testDisabled();
    enable = 1'b0;
    timerInterval = 16'd3;
    continuousEn = 1'b1;
    setUtil(10);
    utilPulses = 0; timerPulses = 0;
    sendFrames(10);
    tickN(12);
    idle(3);
    checkEq("R1", "util pulses while disabled", utilPulses, 0);
    checkEq("R1", "timer pulses while disabled", timerPulses, 0);
    timerInterval = 16'd0;
    continuousEn = 1'b0;
    @(negedge clk) enable = 1'b1;
    idle(1);
    sendFrames(1);
    idle(3);
    checkEq("R1", "frames while disabled were dropped", utilPulses, 0);
    sendFrames(1);
    idle(3);
    checkEq("R4", "band A pulse after two frames", utilPulses, 1);
  endtask

  task automatic testBands();
    restart();
    setUtil(50);  // equal to the band B bound
    sendFrames(3);
    idle(3);
    checkEq("R2", "band B below threshold", utilPulses, 0);
    sendFrames(1);
    idle(3);
    checkEq("R2", "band B at threshold", utilPulses, 1);
    setUtil(51);  // band C
    sendFrames(5);
    idle(3);
    checkEq("R2", "band C below threshold", utilPulses, 1);
    sendFrames(1);
    idle(3);
    checkEq("R2", "band C at threshold", utilPulses, 2);
    setBands(20, 50, 80, 95, 0, 4, 6, 8);  // zero threshold acts as one
    setUtil(5);
    idle(3);
    checkEq("R2", "zero threshold with no frames", utilPulses, 2);
    sendFrames(1);
    idle(3);
    checkEq("R2", "zero threshold after one frame", utilPulses, 3);
    setBands(20, 50, 80, 95, 2, 4, 6, 8);
  endtask

  task automatic testAbove();
    restart();
    setUtil(99);
    sendFrames(20);
    idle(3);
    checkEq("R3", "no pulse above all bounds", utilPulses, 0);
    setUtil(10);
    idle(4);
    checkEq("R3", "frames kept counting above bounds", utilPulses, 1);
  endtask

  task automatic testTiming();
    restart();
    setUtil(10);
    @(negedge clk) frameDone = 1'b1;
    @(negedge clk) frameDone = 1'b1;
    @(negedge clk) frameDone = 1'b0;
    checkEq("R4", "utilIrq as count reaches threshold", int'(utilIrq), 0);
    @(negedge clk);
    checkEq("R4", "utilIrq one cycle later", int'(utilIrq), 1);
    @(negedge clk);
    checkEq("R4", "utilIrq is a single pulse", int'(utilIrq), 0);
    utilPulses = 0;
    sendFrames(3);  // the third frame lands in the firing cycle
    idle(3);
    checkEq("R5", "one pulse for three frames", utilPulses, 1);
    sendFrames(1);
    idle(3);
    checkEq("R5", "frame in firing cycle was counted", utilPulses, 2);
  endtask

  task automatic testSaturate();
    restart();
    setUtil(99);
    sendFrames(65600);
    setBands(20, 50, 80, 95, 2, 4, 6, 65535);
    setUtil(90);  // band D
    idle(4);
    checkEq("R6", "saturated count meets 65535", utilPulses, 1);
    setBands(20, 50, 80, 95, 2, 4, 6, 8);
  endtask

  task automatic testTimerTraffic();
    timerInterval = 16'd5;
    continuousEn = 1'b0;
    autoCancelEn = 1'b0;
    restart();
    setUtil(99);
    tickN(10);
    idle(2);
    checkEq("R7", "no timer pulse without traffic", timerPulses, 0);
    sendFrames(1);
    tickN(5);
    idle(2);
    checkEq("R7", "timer pulse with traffic", timerPulses, 1);
    tickN(5);
    idle(2);
    checkEq("R7", "traffic consumed by expiry", timerPulses, 1);
  endtask

  task automatic testContinuous();
    timerInterval = 16'd5;
    continuousEn = 1'b1;
    restart();
    tickN(20);
    idle(2);
    checkEq("R8", "continuous pulses per interval", timerPulses, 4);
    timerInterval = 16'd0;
    restart();
    tickN(20);
    idle(2);
    checkEq("R7", "zero interval stops timer", timerPulses, 0);
  endtask

  task automatic testAutoCancel();
    timerInterval = 16'd5;
    continuousEn = 1'b1;
    autoCancelEn = 1'b1;
    restart();
    setUtil(10);
    tickN(4);
    sendFrames(2);
    tickN(4);
    idle(2);
    checkEq("R9", "util pulse issued", utilPulses, 1);
    checkEq("R9", "timer restarted by util pulse", timerPulses, 0);
    tickN(1);
    idle(2);
    checkEq("R9", "timer expires a full interval later", timerPulses, 1);
    autoCancelEn = 1'b0;
    restart();
    tickN(4);
    sendFrames(2);
    tickN(1);
    idle(2);
    checkEq("R10", "no restart without auto-cancel", timerPulses, 1);
  endtask

  task automatic testIndependent();
    timerInterval = 16'd3;
    continuousEn = 1'b1;
    autoCancelEn = 1'b0;
    restart();
    tickN(2);
    @(negedge clk) frameDone = 1'b1;
    @(negedge clk) frameDone = 1'b1;
    @(negedge clk) begin frameDone = 1'b0; usTick = 1'b1; end
    @(negedge clk) usTick = 1'b0;
    checkEq("R10", "utilIrq in shared cycle", int'(utilIrq), 1);
    checkEq("R10", "timerIrq in shared cycle", int'(timerIrq), 1);
  endtask

  initial begin
    setBands(20, 50, 80, 95, 2, 4, 6, 8);
    idle(3);
    testReset();
    @(negedge clk) rstN = 1'b1;
    idle(2);
    testReset();
    testDisabled();
    testBands();
    testAbove();
    testTiming();
    testSaturate();
    testTimerTraffic();
    testContinuous();
    testAutoCancel();
    testIndependent();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule